// File: doc/BRIEF.md
# Chainable Serial Settings Port

This block is a serial slave that receives a 16-bit settings word. It holds the decoded fields in a settings register that drives a preamplifier's control pins. A host drives an active-low select, a serial clock and a data line. Data enters a 16-bit shift register on rising serial-clock edges. The most significant bit of that register is driven out on falling edges. Because of this, the data output of one port can feed the data input of the next, and N ports act as one shift register of 16×N bits. The word for the port farthest down the chain is sent first.

New settings take effect only when the select rises. Until then the outputs keep the last committed word. The select, the serial clock and the data input are brought into the system clock domain through two-flop synchronizers and edge detectors. The data output is a plain data bit paired with an output-enable, which an external pad buffer uses to tri-state the line.

The sequencer has three states. `ST_IDLE` means the select is high. `ST_SHIFT` means the select is low and bits are moving. `ST_COMMIT` is a one-cycle state in which the shift register is copied into the settings register. The transitions are:
- `ST_IDLE` to `ST_SHIFT` on a select fall.
- `ST_SHIFT` to `ST_COMMIT` on a select rise.
- `ST_COMMIT` to `ST_IDLE` when the select stays high.
- `ST_COMMIT` to `ST_SHIFT` when the select falls again in the commit cycle.

Top module: `ctl_serial_port`

## Requirements
- R1: After reset, the shift register and the settings register are zero. Every settings output is 0 and `sdo_oe_o` is 0.
- R2: The word is sent most significant bit first. Its bit positions decode as follows:
  - Bit 15 is `servo_off_o`, which is active high to disable the servo.
  - Bit 14 is `cm_en_o`.
  - Bit 13 is `zc_en_o`.
  - Bit 12 is `ovr_sel_o`.
  - Bits 11 down to 8 are `gpo_o[3]` down to `gpo_o[0]`.
  - Bits 7 and 6 are reserved and have no output.
  - Bits 5 down to 0 are `gain_o[5:0]`.
- R3: With the select low, each rising serial-clock edge shifts the current `sdi_i` into bit 0 and moves every other bit up by one.
- R4: `sdo_o` shows bit 15 of the shift register. It is loaded when the select falls and reloaded on each falling serial-clock edge while the select is low, so before each rising edge it carries the bit that edge pushes out.
- R5: The settings outputs change only after a select rise. They hold their values while bits are shifting.
- R6: While the select is high, serial-clock and data activity changes neither the shift register nor the outputs.
- R7: When two ports are chained and 32 bits are sent, the first 16 bits land in the far port and the last 16 in the near port.
- R8: If the number of bits sent is not a multiple of 16, the last 16 bits received are committed.
- R9: `sdo_oe_o` is high only while the synchronized select is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the serial clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| csn_i | input | 1 | Active-low select and commit strobe |
| sck_i | input | 1 | Serial clock |
| sdi_i | input | 1 | Serial data in |
| sdo_o | output | 1 | Serial data out (bit 15 of the shift register) |
| sdo_oe_o | output | 1 | Enable for the serial data out pad |
| gpo_o | output | 4 | General-purpose outputs |
| servo_off_o | output | 1 | Servo disable |
| cm_en_o | output | 1 | Common-mode servo enable |
| zc_en_o | output | 1 | Zero-cross gain switching enable |
| ovr_sel_o | output | 1 | Over-range threshold select |
| gain_o | output | 6 | Gain code |

## Verification
The assertions assume the following about the inputs:
- The serial clock is slow against the system clock, so each synchronized rise and fall is seen as a separate edge.
- A select edge never lands in the same system cycle as a serial-clock edge.
- `sdi_i` is stable across the synchronizer delay around each rising serial-clock edge.

The stimulus keeps within these limits. It holds every serial-clock phase for eight system clocks and changes data only on falling edges. It waits several clocks between select edges and serial-clock edges. It also toggles the serial clock only when the select is high or well clear of select edges.

// File: rtl/ctl_port_pkg.sv
package ctl_port_pkg;
    localparam int WORD_W = 16;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SHIFT,
        ST_COMMIT
    } port_state_e;

    typedef struct packed {
        logic       servo_off;
        logic       cm_en;
        logic       zc_en;
        logic       ovr_sel;
        logic [3:0] gpo;
        logic [1:0] rsvd;
        logic [5:0] gain;
    } ctl_word_t;
endpackage

// File: rtl/ctl_sync.sv
module ctl_sync #(
    parameter int          W       = 1,
    parameter int          STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q,
    output logic [W-1:0] rise,
    output logic [W-1:0] fall
);
    // pipe[0..STAGES-1] synchronize; pipe[STAGES] keeps the previous value
    logic [STAGES:0][W-1:0] pipe;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pipe <= {(STAGES+1){RST_VAL}};
        end else begin
            pipe <= {pipe[STAGES-1:0], d};
        end
    end

    assign q    = pipe[STAGES-1];
    assign rise = pipe[STAGES-1] & ~pipe[STAGES];
    assign fall = ~pipe[STAGES-1] & pipe[STAGES];
endmodule

// File: rtl/ctl_shift_fsm.sv
module ctl_shift_fsm
    import ctl_port_pkg::*;
#(
    parameter int W = WORD_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cs_rise,
    input  logic         cs_fall,
    input  logic         sck_rise,
    input  logic         sck_fall,
    input  logic         sdi,
    output port_state_e  state,
    output logic [W-1:0] shreg,
    output logic         sdo,
    output logic         sdo_oe,
    output logic         commit
);
    port_state_e state_q, state_d;
    logic [W-1:0] shreg_q;
    logic         sdo_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (cs_fall) state_d = ST_SHIFT;
            ST_SHIFT:  if (cs_rise) state_d = ST_COMMIT;
            ST_COMMIT: state_d = cs_fall ? ST_SHIFT : ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // datapath: shift on rising serial edges, present MSB on falling ones
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg_q <= '0;
            sdo_q   <= 1'b0;
        end else begin
            if (state_q == ST_SHIFT && sck_rise && !cs_rise) begin
                shreg_q <= {shreg_q[W-2:0], sdi};
            end
            if (cs_fall && state_q != ST_SHIFT) begin
                sdo_q <= shreg_q[W-1];
            end else if (state_q == ST_SHIFT && sck_fall) begin
                sdo_q <= shreg_q[W-1];
            end
        end
    end

    always_comb begin
        sdo_oe = (state_q == ST_SHIFT);
        commit = (state_q == ST_COMMIT);
    end

    assign state = state_q;
    assign shreg = shreg_q;
    assign sdo   = sdo_q;
endmodule

// File: rtl/ctl_serial_port.sv
module ctl_serial_port
    import ctl_port_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       csn_i,
    input  logic       sck_i,
    input  logic       sdi_i,
    output logic       sdo_o,
    output logic       sdo_oe_o,
    output logic [3:0] gpo_o,
    output logic       servo_off_o,
    output logic       cm_en_o,
    output logic       zc_en_o,
    output logic       ovr_sel_o,
    output logic [5:0] gain_o
);
    localparam int NSYNC = 3; // {select, serial clock, data}

    logic [NSYNC-1:0] sync_q, sync_rise, sync_fall;
    port_state_e      fsm_state;
    logic [WORD_W-1:0] shreg;
    logic             commit;
    ctl_word_t        ctl_q;

    ctl_sync #(
        .W(NSYNC), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)
    ) sync_i (
        .clk(clk), .rst_n(rst_n), .d({csn_i, sck_i, sdi_i}),
        .q(sync_q), .rise(sync_rise), .fall(sync_fall)
    );

    ctl_shift_fsm #(.W(WORD_W)) fsm_i (
        .clk(clk), .rst_n(rst_n),
        .cs_rise(sync_rise[2]), .cs_fall(sync_fall[2]),
        .sck_rise(sync_rise[1]), .sck_fall(sync_fall[1]),
        .sdi(sync_q[0]),
        .state(fsm_state), .shreg(shreg),
        .sdo(sdo_o), .sdo_oe(sdo_oe_o), .commit(commit)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      ctl_q <= '0;
        else if (commit) ctl_q <= ctl_word_t'(shreg);
    end

    assign servo_off_o = ctl_q.servo_off;
    assign cm_en_o     = ctl_q.cm_en;
    assign zc_en_o     = ctl_q.zc_en;
    assign ovr_sel_o   = ctl_q.ovr_sel;
    assign gain_o      = ctl_q.gain;

    for (genvar g = 0; g < 4; g++) begin : g_gpo
        assign gpo_o[g] = ctl_q.gpo[g];
    end

    logic unused_bits;
    assign unused_bits = ^{ctl_q.rsvd, sync_q[2:1], sync_rise[0], sync_fall[0]};
endmodule

// File: rtl/ctl_serial_port_chk.sv
module ctl_serial_port_chk
    import ctl_port_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input port_state_e       state,
    input logic [WORD_W-1:0] shreg,
    input logic              sck_fall,
    input logic              sdo_o,
    input logic              sdo_oe_o,
    input logic [13:0]       outs
);
    AST_COMMIT_COPIES_FIELDS: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_COMMIT |=> outs == $past({shreg[15:8], shreg[5:0]})); // R2

    AST_OUTS_HOLD_OFF_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        state != ST_COMMIT |=> $stable(outs)); // R5

    AST_IDLE_KEEPS_SHREG: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_IDLE |=> $stable(shreg)); // R6

    AST_SDO_HOLDS_BETWEEN_FALLS: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SHIFT && !sck_fall) |=> $stable(sdo_o)); // R4

    AST_OE_LOW_IN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_IDLE |-> !sdo_oe_o); // R9
endmodule

bind ctl_serial_port ctl_serial_port_chk chk_i (
    .clk(clk), .rst_n(rst_n), .state(fsm_state), .shreg(shreg),
    .sck_fall(sync_fall[1]), .sdo_o(sdo_o), .sdo_oe_o(sdo_oe_o),
    .outs({servo_off_o, cm_en_o, zc_en_o, ovr_sel_o, gpo_o, gain_o})
);

// File: tb/ctl_serial_port_tb.sv
module ctl_serial_port_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic csn = 1'b1, sck = 1'b0, sdi = 1'b0;
    logic sdo1, oe1, sdo2, oe2;
    logic [3:0] gpo1, gpo2;
    logic so1, cm1, zc1, ov1, so2, cm2, zc2, ov2;
    logic [5:0] gain1, gain2;

    int checks = 0;
    int errors = 0;
    int settle = 0;
    bit done = 0;

    // behavioural model: 32-bit chain, near port = low half
    logic [31:0] chain = '0;
    logic [15:0] exp1 = '0, exp2 = '0;

    always #10 clk = ~clk;

    ctl_serial_port dut_i (
        .clk(clk), .rst_n(rst_n), .csn_i(csn), .sck_i(sck), .sdi_i(sdi),
        .sdo_o(sdo1), .sdo_oe_o(oe1), .gpo_o(gpo1), .servo_off_o(so1),
        .cm_en_o(cm1), .zc_en_o(zc1), .ovr_sel_o(ov1), .gain_o(gain1)
    );

    ctl_serial_port dut2_i (
        .clk(clk), .rst_n(rst_n), .csn_i(csn), .sck_i(sck), .sdi_i(sdo1),
        .sdo_o(sdo2), .sdo_oe_o(oe2), .gpo_o(gpo2), .servo_off_o(so2),
        .cm_en_o(cm2), .zc_en_o(zc2), .ovr_sel_o(ov2), .gain_o(gain2)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, expv, $time);
        end
    endtask

    function automatic logic [13:0] fields(input logic [15:0] w);
        // R2 layout: 15 servo_off, 14 cm, 13 zc, 12 ovr, 11:8 gpo[3:0], 5:0 gain
        return {w[15], w[14], w[13], w[12], w[11:8], w[5:0]};
    endfunction

    // per-clock comparison against the model once select edges have settled (R5, R9)
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (settle < 1000) settle++;
            if (settle >= 6) begin
                check("R5 near", {18'd0, so1, cm1, zc1, ov1, gpo1, gain1}, {18'd0, fields(exp1)});
                check("R5 far",  {18'd0, so2, cm2, zc2, ov2, gpo2, gain2}, {18'd0, fields(exp2)});
                check("R9 oe", {30'd0, oe1, oe2}, {30'd0, !csn, !csn});
            end
        end
    end

    task automatic half_wait();
        repeat (8) @(negedge clk);
    endtask

    task automatic send(input int n, input logic [63:0] bits);
        csn = 1'b0; settle = 0;
        half_wait();
        for (int i = n - 1; i >= 0; i--) begin
            sdi = bits[i];
            half_wait();
            check("R4 sdo", {31'd0, sdo1}, {31'd0, chain[15]});
            sck = 1'b1;
            chain = {chain[30:0], bits[i]};
            half_wait();
            sck = 1'b0;
        end
        half_wait();
        csn = 1'b1; settle = 0;
        exp1 = chain[15:0];
        exp2 = chain[31:16];
        repeat (12) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 near", {17'd0, oe1, so1, cm1, zc1, ov1, gpo1, gain1}, 32'd0);
        check("R1 far",  {17'd0, oe2, so2, cm2, zc2, ov2, gpo2, gain2}, 32'd0);
        rst_n = 1'b1;
        repeat (10) @(negedge clk);
        check("R1 sdo after reset", {31'd0, sdo1}, 32'd0);

        // R2/R3: single word, MSB first, decoded fields
        send(16, 64'h0000_0000_0000_A5C3);
        check("R2 servo_off", {31'd0, so1}, 32'd1);
        check("R2 cm_en", {31'd0, cm1}, 32'd0);
        check("R2 zc_en", {31'd0, zc1}, 32'd1);
        check("R2 ovr_sel", {31'd0, ov1}, 32'd0);
        check("R2 gpo", {28'd0, gpo1}, 32'h5);
        check("R3 gain", {26'd0, gain1}, 32'h03);
        check("R7 far gets old near word", {16'd0, so2, cm2, zc2, ov2, gpo2, 2'b00, gain2}, 32'd0);

        send(16, 64'h0000_0000_0000_5A3C);
        check("R3 second word gain", {26'd0, gain1}, 32'h3C);
        check("R4 far gets shifted-out word", {26'd0, gain2}, 32'h03);

        // R6: activity while select high is ignored
        for (int k = 0; k < 20; k++) begin
            sdi = k[0]; sck = 1'b1; half_wait(); sck = 1'b0; half_wait();
        end
        check("R6 oe stays low", {31'd0, oe1}, 32'd0);
        check("R6 gain held", {26'd0, gain1}, 32'h3C);
        // the next transfer's SDO checks prove the shift register was untouched

        // R7: 32-bit chain load
        send(32, 64'h0000_0000_8F15_7FFF);
        check("R7 far word", {18'd0, so2, cm2, zc2, ov2, gpo2, gain2}, {18'd0, fields(16'h8F15)});
        check("R7 near word", {18'd0, so1, cm1, zc1, ov1, gpo1, gain1}, {18'd0, fields(16'h7FFF)});

        // R8: 20 bits, last 16 committed
        send(20, 64'h0000_0000_000F_1E2D);
        check("R8 near gain", {26'd0, gain1}, {26'd0, 6'h2D});
        check("R8 near gpo", {28'd0, gpo1}, 32'hE);
        check("R8 far", {18'd0, so2, cm2, zc2, ov2, gpo2, gain2}, {18'd0, fields(chain[31:16])});

        send(16, 64'h0);
        check("R3 all zero word", {26'd0, gain1}, 32'd0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule